// File: doc/BRIEF.md
# Small Content-Addressable Memory with Selectable Match Reporting

This block is a compact content-addressable memory. It stores a small set of byte-wide words, each with a valid flag. A write port loads a word into an addressed slot. A search port compares a key with every valid slot in a single cycle. The result is registered and comes out one cycle after the key.

The result takes one of two forms, chosen per search. In encoded mode the block reports the lowest-numbered slot that hit, together with a hit flag and a flag for more than one hit. In vector mode it reports one bit per slot. A clear command removes either one addressed slot or every slot in one cycle.

Top module: `cam_array`

## Requirements
- R1: After reset every slot is invalid, and a search returns no hit: hit=0, multi=0, vector all zeros, index 0.
- R2: A write stores the data in the addressed slot and marks it valid. A search that starts on the following cycle sees the new word.
- R3: Search results appear on the outputs exactly one cycle after srch_vld is high, and res_vld pulses for that cycle only.
- R4: In encoded mode (srch_mode=0) res_index is the lowest-numbered valid slot whose word equals the key. res_hit is 1 when at least one slot hits. res_multi is 1 when two or more slots hit. res_vec reads all zeros.
- R5: In vector mode (srch_mode=1) bit i of res_vec is 1 exactly when slot i is valid and holds the key. res_hit and res_multi follow the same rules as in encoded mode, and res_index reads 0.
- R6: A clear with clr_all=0 invalidates only the slot at clr_addr. A clear with clr_all=1 invalidates every slot. Either takes effect for searches on the next cycle.
- R7: Invalid slots never hit, whatever stale data they hold.
- R8: When a write and a clear arrive in the same cycle, the clear wins for the slots it covers.
- R9: When no search is requested, the result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Slot to write |
| wr_data | input | 8 | Word to store |
| clr_en | input | 1 | Clear request |
| clr_all | input | 1 | 1: clear all slots, 0: clear one slot |
| clr_addr | input | 4 | Slot to clear when clr_all=0 |
| srch_vld | input | 1 | Search request |
| srch_mode | input | 1 | 0 encoded, 1 vector |
| srch_key | input | 8 | Key to look up |
| res_vld | output | 1 | Result strobe |
| res_hit | output | 1 | At least one hit |
| res_multi | output | 1 | Two or more hits |
| res_index | output | 4 | Lowest hitting slot (encoded mode) |
| res_vec | output | 16 | Per-slot hit bits (vector mode) |

## Verification
A stale or wrong valid flag, or a corrupted word, shows up on the very next search for that value. It appears as a missing or extra bit in res_vec, or as a wrong lowest index. The bench therefore keeps a shadow copy of the slots and searches after every kind of update. A wrong priority order only shows when several slots hold the same word, so duplicates are planted on purpose. A broken result register shows as a strobe or value that is off by one cycle.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic {MODE_ENC = 1'b0, MODE_VEC = 1'b1} cam_mode_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
   parameter int ENTRIES = 16,
   parameter int WIDTH   = 8,
   localparam int AW     = $clog2(ENTRIES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [WIDTH-1:0]          wr_data,
   input  logic                      clr_en,
   input  logic                      clr_all,
   input  logic [AW-1:0]             clr_addr,
   output logic [ENTRIES-1:0][WIDTH-1:0] words,
   output logic [ENTRIES-1:0]        valid
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic wsel, csel;
      assign wsel = wr_en && (wr_addr == AW'(i));
      assign csel = clr_en && (clr_all || (clr_addr == AW'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[i] <= '0;
            valid[i] <= 1'b0;
         end else begin
            if (wsel) words[i] <= wr_data;
            if (csel)      valid[i] <= 1'b0;
            else if (wsel) valid[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cam_match.sv
module cam_match #(
   parameter int ENTRIES = 16,
   parameter int WIDTH   = 8,
   localparam int AW     = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0][WIDTH-1:0] words,
   input  logic [ENTRIES-1:0]        valid,
   input  logic [WIDTH-1:0]          key,
   output logic [ENTRIES-1:0]        hits,
   output logic [AW-1:0]             first,
   output logic                      any,
   output logic                      many
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hits[i] = valid[i] && (words[i] == key);
   end

   always_comb begin
      first = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (hits[i]) first = AW'(i);
   end

   assign any  = |hits;
   assign many = (hits & (hits - 1'b1)) != '0;
endmodule

// File: rtl/cam_array.sv
module cam_array
   import cam_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int WIDTH   = 8,
   localparam int AW     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [WIDTH-1:0]   wr_data,
   input  logic               clr_en,
   input  logic               clr_all,
   input  logic [AW-1:0]      clr_addr,
   input  logic               srch_vld,
   input  logic               srch_mode,
   input  logic [WIDTH-1:0]   srch_key,
   output logic               res_vld,
   output logic               res_hit,
   output logic               res_multi,
   output logic [AW-1:0]      res_index,
   output logic [ENTRIES-1:0] res_vec
);
   initial begin
      assert (ENTRIES >= 2 && (1 << AW) == ENTRIES)
         else $error("ENTRIES must be a power of two, at least 2");
      assert (WIDTH >= 1) else $error("WIDTH must be positive");
   end

   logic [ENTRIES-1:0][WIDTH-1:0] words;
   logic [ENTRIES-1:0] valid, hits;
   logic [AW-1:0]      first;
   logic               any, many;

   cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .clr_en, .clr_all, .clr_addr, .words, .valid);

   cam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
      .words, .valid, .key(srch_key), .hits, .first, .any, .many);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld   <= 1'b0;
         res_hit   <= 1'b0;
         res_multi <= 1'b0;
         res_index <= '0;
         res_vec   <= '0;
      end else begin
         res_vld <= srch_vld;
         if (srch_vld) begin
            res_hit   <= any;
            res_multi <= many;
            if (cam_mode_e'(srch_mode) == MODE_VEC) begin
               res_vec   <= hits;
               res_index <= '0;
            end else begin
               res_vec   <= '0;
               res_index <= first;
            end
         end
      end
   end
endmodule

// File: rtl/cam_array_checker.sv
module cam_array_checker #(
   parameter int ENTRIES = 16,
   localparam int AW = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               srch_vld,
   input logic               srch_mode,
   input logic               res_vld,
   input logic               res_hit,
   input logic               res_multi,
   input logic [AW-1:0]      res_index,
   input logic [ENTRIES-1:0] res_vec
);
   AST_RES_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      srch_vld |=> res_vld); // R3
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_vld |=> !res_vld); // R3
   AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      res_multi |-> res_hit); // R4
   AST_ENC_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_vld && !srch_mode) |=> res_vec == '0); // R4
   AST_VEC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_vld && srch_mode) |=> (res_hit == (res_vec != '0)) &&
         (res_multi == ($countones(res_vec) > 1)) && res_index == '0); // R5
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_vld |=> $stable(res_vec) && $stable(res_index) && $stable(res_hit)); // R9
endmodule

bind cam_array cam_array_checker #(.ENTRIES(ENTRIES)) u_chk (
   .clk, .rst_n, .srch_vld, .srch_mode, .res_vld, .res_hit,
   .res_multi, .res_index, .res_vec);

// File: tb/cam_array_test.sv
module cam_array_test;
   logic clk = 0, rst_n = 0;
   logic wr_en = 0, clr_en = 0, clr_all = 0, srch_vld = 0, srch_mode = 0;
   logic [3:0] wr_addr = 0, clr_addr = 0;
   logic [7:0] wr_data = 0, srch_key = 0;
   logic res_vld, res_hit, res_multi;
   logic [3:0] res_index;
   logic [15:0] res_vec;

   int checks = 0, errors = 0;
   logic [7:0] m_word [16];
   logic [15:0] m_val;

   always #2.5 clk = ~clk;

   cam_array uut (.*);

   function automatic logic [15:0] exp_vec(input logic [7:0] k);
      logic [15:0] v = '0;
      for (int i = 0; i < 16; i++) v[i] = m_val[i] && (m_word[i] == k);
      return v;
   endfunction

   function automatic logic [3:0] exp_idx(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
      return 4'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
      m_word[a] = d; m_val[a] = 1'b1;
   endtask

   task automatic clr(input logic all, input logic [3:0] a);
      @(negedge clk); clr_en = 1; clr_all = all; clr_addr = a;
      @(negedge clk); clr_en = 0;
      if (all) m_val = '0; else m_val[a] = 1'b0;
   endtask

   // search and check the result one cycle later
   task automatic srch(input string req, input logic mode, input logic [7:0] k);
      logic [15:0] v;
      @(negedge clk); srch_vld = 1; srch_mode = mode; srch_key = k;
      v = exp_vec(k);
      @(negedge clk); srch_vld = 0;
      chk({req, " vld"}, 32'(res_vld), 32'd1);
      chk({req, " hit"}, 32'(res_hit), 32'(v != 0));
      chk({req, " multi"}, 32'(res_multi), 32'($countones(v) > 1));
      chk({req, " idx"}, 32'(res_index), mode ? 32'd0 : 32'(exp_idx(v)));
      chk({req, " vec"}, 32'(res_vec), mode ? 32'(v) : 32'd0);
   endtask

   initial begin
      #100000;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(1234);
      m_val = '0;
      for (int i = 0; i < 16; i++) m_word[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset vld", 32'(res_vld), 0);
      chk("R1 reset vec", 32'(res_vec), 0);
      rst_n = 1;
      srch("R1 empty", 1, 8'h00);
      // R2 write then search next cycle
      wr(4'd5, 8'hA5);
      srch("R2 single", 0, 8'hA5);
      // R4 priority with duplicates
      wr(4'd12, 8'h3C); wr(4'd3, 8'h3C); wr(4'd9, 8'h3C);
      srch("R4 lowest", 0, 8'h3C);
      srch("R5 vector", 1, 8'h3C);
      // R9 hold
      repeat (2) @(negedge clk);
      chk("R9 hold vec", 32'(res_vec), 32'(exp_vec(8'h3C)));
      chk("R3 strobe low", 32'(res_vld), 0);
      // R6 single clear
      clr(0, 4'd3);
      srch("R6 one clear", 0, 8'h3C);
      // R7 stale data in cleared slot
      srch("R7 stale", 1, 8'h3C);
      // R8 write and clear same cycle
      @(negedge clk); wr_en = 1; wr_addr = 4'd7; wr_data = 8'h77;
      clr_en = 1; clr_all = 0; clr_addr = 4'd7;
      @(negedge clk); wr_en = 0; clr_en = 0;
      m_word[7] = 8'h77; m_val[7] = 0;
      srch("R8 clr wins", 1, 8'h77);
      // R6 clear all
      clr(1, 4'd0);
      srch("R6 all", 1, 8'h3C);
      srch("R6 all enc", 0, 8'hA5);
      // back-to-back searches
      wr(4'd15, 8'h01); wr(4'd0, 8'h02);
      @(negedge clk); srch_vld = 1; srch_mode = 0; srch_key = 8'h01;
      @(negedge clk); srch_key = 8'h02; srch_mode = 1;
      chk("R3 b2b idx", 32'(res_index), 32'd15);
      @(negedge clk); srch_vld = 0;
      chk("R3 b2b vec", 32'(res_vec), 32'h0001);
      // random mix over a small key space to get duplicates
      for (int n = 0; n < 400; n++) begin
         int op = $urandom_range(0, 9);
         logic [7:0] k = 8'($urandom_range(0, 7));
         if (op < 4) wr(4'($urandom_range(0, 15)), 8'($urandom_range(0, 7)));
         else if (op == 4) clr(($urandom_range(0, 9) == 0), 4'($urandom_range(0, 15)));
         else srch(op[0] ? "R5 rand" : "R4 rand", op[0], k);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule